// File: doc/BRIEF.md
# Low-Voltage Detect Reset Controller

This block is the digital side of a supply-voltage monitor. An analog comparator outside the block reports whether the supply is below a chosen detection level. The block tells that comparator which of two levels to use, brings the comparator's answer into the clock domain, and then responds in one of two ways. In interrupt mode it raises a single-cycle interrupt whenever the supply crosses from good to low. In reset mode it holds an internal system reset for as long as the supply stays low.

Once reset mode is armed, software can no longer change the mode, the enable or the level select. Only the external reset input releases that lock. While the low-voltage reset is active, the main-oscillator enable is deasserted. When the reset ends, the oscillator is re-enabled and the CPU is held for a programmable stabilization interval before it may start. Software uses a small register bus to set up the block and to read a live status flag, which lets it confirm that the supply is good before it arms reset mode.

Top module: `lvd_reset_ctrl`

## Requirements
- R1: After the external reset `rst_n`, the following values hold: enable, mode and level select are 0; the stabilization field holds `STAB_RST` (default 0); `sys_rst_o`, `lvd_irq_o` and `cpu_hold_o` are 0; `osc_en_o` is 1.
- R2: `cmp_below_i` passes through a two-flop synchronizer. A change on it that is set up before rising edge j first affects `lvd_irq_o` and `sys_rst_o` after rising edge j+2.
- R3: With enable 1 and mode 0, every change of the synchronized comparator from 0 (above) to 1 (below) produces a one-cycle pulse on `lvd_irq_o`. `sys_rst_o` stays 0.
- R4: With enable 1 and mode 1, `sys_rst_o` is 1 exactly while the synchronized comparator reads 1, delayed by one register. `lvd_irq_o` stays 0.
- R5: `osc_en_o` is 0 during every cycle in which `sys_rst_o` is 1, and is 1 otherwise.
- R6: `cpu_hold_o` is 1 while `sys_rst_o` is 1. After `sys_rst_o` falls, it stays 1 for exactly 2^(10+N) more cycles, counted from the first cycle with `osc_en_o` high. N is the stabilization field.
- R7: While mode is 1, writes to the control register (address 0) and to the level register (address 1) have no effect. Writes to the stabilization register (address 2) still take effect.
- R8: Only `rst_n` clears enable, mode and the lock.
- R9: Control register bit 2 is read-only and reads as enable AND the synchronized comparator. Bit 0 is enable, bit 1 is mode, and all other bits read 0.
- R10: Level register bit 0 drives `det_level_o`.
- R11: With enable 0, the comparator has no effect: no interrupt, no reset, and status reads 0.
- R12: The stabilization register at address 2 holds N in bits 2:0 and reads back what was written. Reads of address 3 return 0. Reads are combinational from `bus_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External asynchronous active-low reset (non-detector source) |
| cmp_below_i | input | 1 | Asynchronous comparator output, 1 = supply below level |
| det_level_o | output | 1 | Detection-level select to the comparator |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` |
| lvd_irq_o | output | 1 | Low-voltage interrupt pulse |
| sys_rst_o | output | 1 | Internal system reset request |
| osc_en_o | output | 1 | Main-oscillator enable |
| cpu_hold_o | output | 1 | Holds the CPU off until the oscillator is stable |

## Verification
The bench arms reset mode and then tries to clear the enable, the mode and the level by software. A design with a missing lock would drop out of reset mode, and a later supply drop would then produce an interrupt instead of a reset. It measures the hold interval for two values of N. A counter off by one, or one that starts while the reset is still active, would release `cpu_hold_o` a cycle early or late. It also checks the exact edge at which the interrupt appears after a comparator change, which catches a synchronizer that is missing a stage or has an extra one. Finally, it toggles the comparator with enable cleared and confirms that no interrupt, no reset and no status appear.

// File: rtl/lvd_pkg.sv
package lvd_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL  = 2'd0,
    REG_LEVEL = 2'd1,
    REG_STAB  = 2'd2,
    REG_NONE  = 2'd3
  } reg_addr_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_MODE_BIT = 1;
  localparam int CTRL_STAT_BIT = 2;
endpackage

// File: rtl/lvd_sync.sv
module lvd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out,
  output logic sync_prev
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= async_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_prev <= 1'b0;
    else        sync_prev <= chain[STAGES-1];
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/lvd_cfg_regs.sv
module lvd_cfg_regs
  import lvd_pkg::*;
#(
  parameter int STAB_W   = 3,
  parameter int STAB_RST = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              below_sync,
  output logic              en_q,
  output logic              mode_q,
  output logic              level_q,
  output logic [STAB_W-1:0] stab_q,
  output logic [DATA_W-1:0] rdata
);
  logic unused_wdata;
  assign unused_wdata = ^wdata[DATA_W-1:STAB_W];

  // Armed reset mode freezes control and level until rst_n.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      mode_q  <= 1'b0;
      level_q <= 1'b0;
      stab_q  <= STAB_W'(STAB_RST);
    end else if (wr_en) begin
      case (reg_addr_e'(addr))
        REG_CTRL: if (!mode_q) begin
          en_q   <= wdata[CTRL_EN_BIT];
          mode_q <= wdata[CTRL_MODE_BIT];
        end
        REG_LEVEL: if (!mode_q) level_q <= wdata[0];
        REG_STAB:  stab_q <= wdata[STAB_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (reg_addr_e'(addr))
      REG_CTRL: begin
        rdata[CTRL_EN_BIT]   = en_q;
        rdata[CTRL_MODE_BIT] = mode_q;
        rdata[CTRL_STAT_BIT] = en_q & below_sync;
      end
      REG_LEVEL: rdata[0] = level_q;
      REG_STAB:  rdata[STAB_W-1:0] = stab_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/lvd_stab_timer.sv
module lvd_stab_timer #(
  parameter int STAB_W    = 3,
  parameter int STAB_BASE = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_active,
  input  logic [STAB_W-1:0] stab_sel,
  output logic              hold
);
  localparam int CNT_W = STAB_BASE + (1 << STAB_W) - 1;

  logic             counting;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] term;

  always_comb begin
    span = (CNT_W+1)'(1) << (STAB_BASE + int'(stab_sel));
    term = CNT_W'(span - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      counting <= 1'b0;
      cnt      <= '0;
    end else if (rst_active) begin
      counting <= 1'b1;
      cnt      <= '0;
    end else if (counting) begin
      if (cnt == term) counting <= 1'b0;
      else             cnt <= cnt + 1'b1;
    end
  end

  assign hold = rst_active | counting;
endmodule

// File: rtl/lvd_reset_ctrl.sv
module lvd_reset_ctrl
  import lvd_pkg::*;
#(
  parameter int STAB_W      = 3,
  parameter int STAB_BASE   = 10,
  parameter int STAB_RST    = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_below_i,
  output logic              det_level_o,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              lvd_irq_o,
  output logic              sys_rst_o,
  output logic              osc_en_o,
  output logic              cpu_hold_o
);
  logic              below_s, below_prev;
  logic              en_q, mode_q, level_q;
  logic [STAB_W-1:0] stab_q;
  logic              lvd_rst_q, irq_q;

  lvd_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_in(cmp_below_i),
    .sync_out(below_s), .sync_prev(below_prev)
  );

  lvd_cfg_regs #(.STAB_W(STAB_W), .STAB_RST(STAB_RST)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_we_i), .addr(bus_addr_i),
    .wdata(bus_wdata_i), .below_sync(below_s), .en_q(en_q),
    .mode_q(mode_q), .level_q(level_q), .stab_q(stab_q), .rdata(bus_rdata_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvd_rst_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      lvd_rst_q <= en_q & mode_q & below_s;
      irq_q     <= en_q & ~mode_q & below_s & ~below_prev;
    end
  end

  lvd_stab_timer #(.STAB_W(STAB_W), .STAB_BASE(STAB_BASE)) timer_i (
    .clk(clk), .rst_n(rst_n), .rst_active(lvd_rst_q),
    .stab_sel(stab_q), .hold(cpu_hold_o)
  );

  assign sys_rst_o   = lvd_rst_q;
  assign osc_en_o    = ~lvd_rst_q;
  assign lvd_irq_o   = irq_q;
  assign det_level_o = level_q;
endmodule

// File: rtl/lvd_reset_ctrl_chk.sv
module lvd_reset_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic irq,
  input logic sys_rst,
  input logic osc_en,
  input logic cpu_hold,
  input logic en_q,
  input logic mode_q,
  input logic level_q
);
  assert_irq_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_irq_not_in_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq && sys_rst));
  assert_reset_needs_arm_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> (en_q && mode_q));
  assert_hold_covers_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> cpu_hold);
  assert_hold_after_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> (cpu_hold && osc_en));
  assert_hold_drop_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_hold) |-> (osc_en && !sys_rst));
  assert_mode_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |=> (mode_q && en_q));
  assert_level_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |=> $stable(level_q));
endmodule

bind lvd_reset_ctrl lvd_reset_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .irq(lvd_irq_o), .sys_rst(sys_rst_o),
  .osc_en(osc_en_o), .cpu_hold(cpu_hold_o), .en_q(en_q),
  .mode_q(mode_q), .level_q(level_q)
);

// File: tb/lvd_reset_ctrl_tb_top.sv
module lvd_reset_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       det_level, irq, sys_rst, osc_en, cpu_hold;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string rd_tag = "R1";

  always #5 clk = ~clk;

  lvd_reset_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cmp_below_i(cmp), .det_level_o(det_level),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .lvd_irq_o(irq), .sys_rst_o(sys_rst), .osc_en_o(osc_en), .cpu_hold_o(cpu_hold)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit m_en, m_mode, m_lvl, m_rst, m_irq;
  int m_stab = 0;
  int remain = 0;
  bit d1, sb, sbp;

  function automatic int exp_rdata(input logic [1:0] a);
    case (a)
      2'd0: return {(m_en && sb), m_mode, m_en};
      2'd1: return m_lvl;
      2'd2: return m_stab;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_mode = 0; m_lvl = 0; m_rst = 0; m_irq = 0;
      m_stab = 0; remain = 0; d1 = 0; sb = 0; sbp = 0;
    end else begin
      bit n_rst, n_irq;
      n_rst = m_en && m_mode && sb;
      n_irq = m_en && !m_mode && sb && !sbp;
      if (m_rst) remain = 1 << (10 + m_stab);
      else if (remain > 0) remain--;
      m_rst = n_rst;
      m_irq = n_irq;
      sbp = sb; sb = d1; d1 = cmp;
      if (we) begin
        case (addr)
          2'd0: if (!m_mode) begin m_en = wdata[0]; m_mode = wdata[1]; end
          2'd1: if (!m_mode) m_lvl = wdata[0];
          2'd2: m_stab = wdata[2:0];
          default: ;
        endcase
      end
    end
    #2;
    if (!done) begin
      chk("R4 sys_rst", sys_rst, m_rst);
      chk("R3 irq", irq, m_irq);
      chk("R5 osc_en", osc_en, !m_rst);
      chk("R6 cpu_hold", cpu_hold, (m_rst || remain > 0));
      chk("R10 det_level", det_level, m_lvl);
      chk({rd_tag, " rdata"}, rdata, exp_rdata(addr));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sys_rst", sys_rst, 0);
    chk("R1 irq", irq, 0);
    chk("R1 osc_en", osc_en, 1);
    chk("R1 cpu_hold", cpu_hold, 0);
    chk("R1 det_level", det_level, 0);
    addr = 2'd0; #1 chk("R1 ctrl", rdata, 0);
    addr = 2'd2; #1 chk("R1 stab", rdata, 0);

    // R12 / R10 register access
    rd_tag = "R12";
    wr(2'd2, 8'hFD);
    addr = 2'd2; #1 chk("R12 stab readback", rdata, 5);
    addr = 2'd3; #1 chk("R12 addr3", rdata, 0);
    rd_tag = "R10";
    wr(2'd1, 8'h01);
    chk("R10 level drive", det_level, 1);
    wr(2'd1, 8'h00);
    chk("R10 level clear", det_level, 0);

    // R11 enable off: comparator ignored
    rd_tag = "R11";
    addr = 2'd0;
    cmp = 1; repeat (6) @(negedge clk);
    chk("R11 status off", rdata, 0);
    chk("R11 no irq", irq, 0);
    chk("R11 no rst", sys_rst, 0);
    cmp = 0; repeat (4) @(negedge clk);

    // R2/R3 interrupt mode and exact latency
    rd_tag = "R9";
    wr(2'd0, 8'h01);
    cmp = 1;
    @(negedge clk); @(negedge clk);
    chk("R2 no irq after 2 edges", irq, 0);
    @(negedge clk);
    chk("R2 irq after 3rd edge", irq, 1);
    @(negedge clk);
    chk("R3 pulse one cycle", irq, 0);
    addr = 2'd0; #1 chk("R9 status below", rdata, 5);
    repeat (5) @(negedge clk);
    cmp = 0; repeat (4) @(negedge clk);
    addr = 2'd0; #1 chk("R9 status good", rdata, 1);
    for (int k = 0; k < 3; k++) begin
      cmp = 1; repeat (3 + k) @(negedge clk);
      cmp = 0; repeat (4) @(negedge clk);
    end

    // Arm reset mode with supply good, N = 1
    rd_tag = "R7";
    wr(2'd1, 8'h01);
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h03);
    wr(2'd0, 8'h00);
    addr = 2'd0; #1 chk("R7 ctrl locked", rdata, 3);
    wr(2'd1, 8'h00);
    chk("R7 level locked", det_level, 1);
    wr(2'd2, 8'h01);
    addr = 2'd2; #1 chk("R7 stab still writable", rdata, 1);

    // R4/R5/R6 reset episode, N = 1
    rd_tag = "R4";
    cmp = 1; repeat (3) @(negedge clk);
    chk("R4 reset asserted", sys_rst, 1);
    chk("R5 osc off", osc_en, 0);
    repeat (15) @(negedge clk);
    chk("R4 no irq in reset mode", irq, 0);
    cmp = 0;
    while (sys_rst) @(negedge clk);
    n = 0;
    while (cpu_hold && n < 5000) begin n++; @(negedge clk); end
    chk("R6 hold length N=1", n, 2048);

    // Second episode, N = 0
    wr(2'd2, 8'h00);
    cmp = 1; repeat (10) @(negedge clk);
    cmp = 0;
    while (sys_rst) @(negedge clk);
    n = 0;
    while (cpu_hold && n < 5000) begin n++; @(negedge clk); end
    chk("R6 hold length N=0", n, 1024);

    // R8 external reset clears the lock
    rd_tag = "R8";
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    addr = 2'd0; #1 chk("R8 cleared", rdata, 0);
    wr(2'd0, 8'h01);
    addr = 2'd0; #1 chk("R8 writable again", rdata, 1);
    cmp = 1; repeat (3) @(negedge clk);
    chk("R8 irq mode again", irq, 1);
    cmp = 0; repeat (5) @(negedge clk);
    finish_run();
  end
endmodule